// File: doc/BRIEF.md
# Reference Clock Switchover Controller

This block picks one of two reference clocks, A or B, and passes it on `clk_out` to a downstream consumer such as a PLL reference pin. A rising edge on the manual request input moves the selection to the other clock. Every later rising edge toggles it again. The falling edge of the request never moves it back.

Each reference clock has its own loss detector. When the active clock is flagged bad and the other clock is healthy, an automatic failover path switches over. While the request input is held high, no new switchover of any kind may start.

All control logic runs on a free-running system clock. The output multiplexer uses a two-phase enable handshake, so the output never carries a shortened pulse. If the clock being switched to is flagged bad, the switch is held pending until that clock comes back. The loss detector is only meaningful when the two reference frequencies are within 20% of each other.

Top module: `clk_switchover_ctrl`

## Requirements
- R1: After reset, `sel_b`=0 (clock A), `bad_a`=`bad_b`=0 and `busy`=0. Once the enable has synchronised, `clk_out` follows `ref_a`.
- R2: A rising edge of `sw_req` (after a two-flop synchroniser) starts a switch to the clock not currently selected. When the switch completes, `sel_b` holds the new selection (0 = A, 1 = B). Each further rising edge toggles it again.
- R3: A falling edge of `sw_req` never changes `sel_b` and never starts a switch.
- R4: A rising edge of `sw_req` that arrives while `busy` is high is ignored, so a burst of edges during one switch toggles the selection only once.
- R5: `busy` is high from the cycle after a request is accepted until the new clock drives `clk_out`. `sel_b` changes only as `busy` falls.
- R6: If the target clock is flagged bad when a switch is requested, the switch waits with `busy` high. During that wait `sel_b` and `clk_out` stay on the old clock. The switch completes once the target is no longer bad.
- R7: While `sw_req` is held high, no new switch starts, including automatic failover.
- R8: Each detector counts rising edges of its reference clock over every window of `WIN_CYCLES` system cycles. At the end of a window it sets the bad flag if fewer than `MIN_EDGES` edges were counted, and clears the flag if the window met the threshold.
- R9: With `sw_req` low, if the active clock is bad and the other clock is not, the block switches to the other clock. If both clocks are bad, nothing happens.
- R10: At most one clock enable is on at any time. Every high and every low phase of `clk_out` lasts at least as long as the shorter source phase, so the output never has a runt pulse.
- R11: A manual switch between two running clocks never raises a bad flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a | input | 1 | Reference clock A |
| ref_b | input | 1 | Reference clock B |
| sw_req | input | 1 | Manual switch request; rising-edge sensitive |
| clk_out | output | 1 | Glitch-free selected clock |
| sel_b | output | 1 | Active clock: 0 = A, 1 = B |
| bad_a | output | 1 | Clock A flagged lost |
| bad_b | output | 1 | Clock B flagged lost |
| busy | output | 1 | Switch in progress |

## Verification
Manual requests come in several shapes:
- short pulses, which show whether each rising edge toggles the selection once;
- long holds followed by a release, which separate rising-edge sensitivity from falling-edge sensitivity;
- bursts of edges inside one switch, which show that edges arriving while busy are ignored.

Random hold and gap lengths then test the toggle model across many request shapes. Reference clocks are stopped and restarted in different orders:
- stopping one clock under a held request shows that failover is blocked;
- stopping one clock and then releasing the request shows that failover fires;
- stopping both clocks shows that no switch happens;
- requesting a switch to a stopped clock shows that the switch waits pending.

A pulse-width monitor on the output watches every phase for runts.

// File: rtl/clk_switchover_ctrl.sv
module clk_switchover_ctrl #(
  parameter int WIN_CYCLES = 64,
  parameter int MIN_EDGES  = 3
) (
  input  logic sys_clk,
  input  logic rst_n,
  input  logic ref_a,
  input  logic ref_b,
  input  logic sw_req,
  output logic clk_out,
  output logic sel_b,
  output logic bad_a,
  output logic bad_b,
  output logic busy
);

  localparam int WW = $clog2(WIN_CYCLES);
  localparam int CW = $clog2(MIN_EDGES + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYCLES - 1);
  localparam logic [CW-1:0] MIN_CNT  = CW'(MIN_EDGES);

  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_DROP, ST_RAISE} st_t;

  logic [1:0]    rclk;
  logic [1:0]    sw_sy;
  logic          sw_d, sw_s, rise;
  logic [2:0]    smp [2];
  logic [CW-1:0] cnt [2];
  logic [WW-1:0] win;
  logic [1:0]    bad, want, en, kill, ack_s1, ack;
  st_t           st;
  logic          tgt, sel;

  assign rclk = {ref_b, ref_a};
  assign sw_s = sw_sy[1];
  assign rise = sw_s & ~sw_d;

  // clock-loss detectors
  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '0;
      bad <= '0;
      for (int g = 0; g < 2; g++) begin
        smp[g] <= '0;
        cnt[g] <= '0;
      end
    end else begin
      win <= (win == WIN_LAST) ? '0 : win + 1'b1;
      for (int g = 0; g < 2; g++) begin
        smp[g] <= {smp[g][1:0], rclk[g]};
        if (win == WIN_LAST) begin
          bad[g] <= (cnt[g] < MIN_CNT);
          cnt[g] <= '0;
        end else if (smp[g][1] && !smp[g][2] && cnt[g] != MIN_CNT) begin
          cnt[g] <= cnt[g] + 1'b1;
        end
      end
    end
  end

  // switch sequencer
  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_sy  <= '0;
      sw_d   <= 1'b0;
      st     <= ST_IDLE;
      tgt    <= 1'b0;
      sel    <= 1'b0;
      want   <= 2'b01;
      kill   <= '0;
      ack_s1 <= '0;
      ack    <= '0;
    end else begin
      sw_sy  <= {sw_sy[0], sw_req};
      sw_d   <= sw_s;
      kill   <= ~want & bad;
      ack_s1 <= en;
      ack    <= ack_s1;
      case (st)
        ST_IDLE:
          if (rise) begin
            tgt <= ~sel;
            if (bad[~sel]) begin
              st <= ST_HOLD;
            end else begin
              st        <= ST_DROP;
              want[sel] <= 1'b0;
            end
          end else if (!sw_s && bad[sel] && !bad[~sel]) begin
            tgt       <= ~sel;
            st        <= ST_DROP;
            want[sel] <= 1'b0;
          end
        ST_HOLD:
          if (!bad[tgt]) begin
            st         <= ST_DROP;
            want[~tgt] <= 1'b0;
          end
        ST_DROP:
          if (!ack[~tgt]) begin
            st        <= ST_RAISE;
            want[tgt] <= 1'b1;
          end
        ST_RAISE:
          if (ack[tgt]) begin
            st  <= ST_IDLE;
            sel <= tgt;
          end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // per-clock enables, changed only while the source is low
  for (genvar g = 0; g < 2; g++) begin : g_en
    logic e1, e2, arst;
    assign arst = ~rst_n | kill[g];
    always_ff @(negedge rclk[g] or posedge arst) begin
      if (arst) begin
        e1 <= 1'b0;
        e2 <= 1'b0;
      end else begin
        e1 <= want[g];
        e2 <= e1;
      end
    end
    assign en[g] = e2;
  end

  assign clk_out = |(rclk & en);
  assign sel_b   = sel;
  assign bad_a   = bad[0];
  assign bad_b   = bad[1];
  assign busy    = (st != ST_IDLE);

  AST_EN_EXCLUSIVE: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $countones(en) <= 1);  // R10
  AST_SEL_NEEDS_BUSY: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !$stable(sel) |-> $past(busy));  // R5
  AST_FALL_NO_SWITCH: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $fell(sw_s) && !busy |=> $stable(sel));  // R3
  AST_HELD_BLOCKS: assert property (@(posedge sys_clk) disable iff (!rst_n)
    sw_s && sw_d && !busy |=> !busy);  // R7
  AST_BUSY_IGNORE: assert property (@(posedge sys_clk) disable iff (!rst_n)
    busy && rise |=> $stable(tgt));  // R4
  AST_HOLD_WAITS: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (st == ST_HOLD) && bad[tgt] |=> (st == ST_HOLD));  // R6
  AST_BAD_AT_WINDOW: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !$stable(bad) |-> ($past(win) == WIN_LAST));  // R8

endmodule

// File: tb/clk_switchover_ctrl_tb.sv
module clk_switchover_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0, ref_a = 1'b0, ref_b = 1'b0, sw_req = 1'b0;
  logic run_a = 1'b1, run_b = 1'b1, mon_on = 1'b0;
  logic clk_out, sel_b, bad_a, bad_b, busy;
  int   errors = 0, checks = 0, runts = 0;
  bit   exp_sel = 1'b0;
  realtime last_t = 0;

  always #2 clk = ~clk;  // 250 MHz

  initial begin #1; forever begin #20; ref_a = run_a ? ~ref_a : 1'b0; end end
  initial begin #3; forever begin #22; ref_b = run_b ? ~ref_b : 1'b0; end end

  clk_switchover_ctrl u_dut (
    .sys_clk(clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b), .sw_req(sw_req),
    .clk_out(clk_out), .sel_b(sel_b), .bad_a(bad_a), .bad_b(bad_b), .busy(busy));

  // R10 runt monitor
  always @(clk_out) begin
    if (mon_on && ($realtime - last_t) < 15.0) runts++;
    last_t = $realtime;
  end

  function automatic bit toggled(input bit s);
    return ~s;
  endfunction

  function automatic bit src_of(input bit s);
    return s ? ref_b : ref_a;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    sw_req = 1'b1; tick(hi);
    sw_req = 1'b0; tick(lo);
  endtask

  task automatic wait_idle(input string rq);
    int n = 0;
    while (busy && n < 3000) begin tick(1); n++; end
    if (busy) chk(1'b0, rq, 1, 0);
  endtask

  task automatic follow(input string rq);
    for (int i = 0; i < 6; i++) begin
      tick(3);
      chk(clk_out == src_of(exp_sel), rq, clk_out, src_of(exp_sel));
    end
  endtask

  task automatic set_run(input bit which, input bit on);
    if (which) run_b = on; else run_a = on;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual=timeout expected=done");
    errors++; checks++;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    tick(5);
    rst_n = 1'b1;
    chk(sel_b == 1'b0, "R1 sel", sel_b, 0);
    chk(!bad_a && !bad_b, "R1 bad", {bad_b, bad_a}, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    tick(40);
    mon_on = 1'b1;
    follow("R1 clk_out");

    // R2 / R5 single manual toggle
    pulse(6, 6);
    chk(busy == 1'b1, "R5 busy during switch", busy, 1);
    chk(sel_b == exp_sel, "R5 sel held while busy", sel_b, exp_sel);
    chk(!bad_a && !bad_b, "R11 no bad mid-switch", {bad_b, bad_a}, 0);
    wait_idle("R5 completion");
    exp_sel = toggled(exp_sel);
    chk(sel_b == exp_sel, "R2 toggle", sel_b, exp_sel);
    follow("R2 clk_out");

    // R3 long hold then release
    sw_req = 1'b1; tick(200);
    wait_idle("R3 hold");
    exp_sel = toggled(exp_sel);
    chk(sel_b == exp_sel, "R3 one toggle on rise", sel_b, exp_sel);
    sw_req = 1'b0; tick(60);
    chk(sel_b == exp_sel, "R3 fall no revert", sel_b, exp_sel);
    chk(busy == 1'b0, "R3 fall no start", busy, 0);

    // R4 burst while busy
    pulse(4, 4);
    chk(busy == 1'b1, "R4 busy before second edge", busy, 1);
    pulse(4, 4);
    wait_idle("R4 completion");
    exp_sel = toggled(exp_sel);
    chk(sel_b == exp_sel, "R4 single toggle", sel_b, exp_sel);

    // random manual sequence, R2 / R11
    for (int it = 0; it < 10; it++) begin
      int hi = 3 + int'($urandom % 60);
      int lo = 3 + int'($urandom % 30);
      pulse(hi, lo);
      tick(4);
      wait_idle("R2 random");
      exp_sel = toggled(exp_sel);
      chk(sel_b == exp_sel, "R2 random toggle", sel_b, exp_sel);
      chk(!bad_a && !bad_b, "R11 random bad", {bad_b, bad_a}, 0);
      chk(clk_out == src_of(exp_sel), "R10 random clk_out", clk_out, src_of(exp_sel));
    end

    // R7 held request blocks failover, R9 failover on release
    sw_req = 1'b1; tick(6);
    wait_idle("R7 hold switch");
    exp_sel = toggled(exp_sel);
    set_run(exp_sel, 1'b0);
    tick(300);
    chk((exp_sel ? bad_b : bad_a) == 1'b1, "R8 active flagged", exp_sel ? bad_b : bad_a, 1);
    chk(sel_b == exp_sel, "R7 no failover while held", sel_b, exp_sel);
    chk(busy == 1'b0, "R7 idle while held", busy, 0);
    sw_req = 1'b0; tick(8);
    wait_idle("R9 failover");
    set_run(exp_sel, 1'b1);
    exp_sel = toggled(exp_sel);
    chk(sel_b == exp_sel, "R9 failover", sel_b, exp_sel);
    follow("R9 clk_out");
    tick(300);
    chk(!bad_a && !bad_b, "R8 flag cleared", {bad_b, bad_a}, 0);

    // R9 both bad: nothing happens
    set_run(!exp_sel, 1'b0); tick(300);
    set_run(exp_sel, 1'b0);  tick(300);
    chk(bad_a && bad_b, "R8 both flagged", {bad_b, bad_a}, 3);
    chk(busy == 1'b0, "R9 both bad idle", busy, 0);
    chk(sel_b == exp_sel, "R9 both bad sel", sel_b, exp_sel);
    set_run(exp_sel, 1'b1);  tick(300);
    set_run(!exp_sel, 1'b1); tick(300);
    chk(!bad_a && !bad_b, "R8 both cleared", {bad_b, bad_a}, 0);
    chk(sel_b == exp_sel, "R9 sel kept", sel_b, exp_sel);

    // R6 pending switch to a lost clock
    set_run(!exp_sel, 1'b0); tick(300);
    pulse(6, 6);
    tick(200);
    chk(busy == 1'b1, "R6 pending busy", busy, 1);
    chk(sel_b == exp_sel, "R6 pending sel", sel_b, exp_sel);
    follow("R6 old clock kept");
    set_run(!exp_sel, 1'b1);
    wait_idle("R6 completion");
    exp_sel = toggled(exp_sel);
    chk(sel_b == exp_sel, "R6 completed", sel_b, exp_sel);
    follow("R6 new clock");

    chk(runts == 0, "R10 runt pulses", runts, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule